// File: doc/BRIEF.md
# Dual-Port Synchronous RAM with Port-to-Port Forwarding

This block is a shared word array reached through two independent ports, X and Y. On each rising clock edge each port captures its address, write data and controls. On the next edge it performs its operation: a read into its output register, a write into the array, or a forward of its own write data straight into the other port's output register. Both ports work on the array in the same cycle. When both ports name the same word, fixed rules decide the outcome, so that software on either side can rely on a known result.

Each port is selected only when both of its chip enables are active, which allows depth expansion across several instances. A per-port output enable gates the registered read data combinationally. An output that is not enabled reads as zero, and the register keeps its contents. After reset is released, the block ignores the first clock edge and raises a ready flag. Address and word widths are parameters.

Top module: `dpr_top`

## Requirements
- R1: A read captured on clock edge N appears on the port's read data after edge N+1, and not after edge N alone.
- R2: A selected port with write enable low (0) and forwarding low stores its write data at the captured address, and a later read returns it. A write leaves that port's read data unchanged.
- R3: A port is selected only when chip enable 1 is low (0) and chip enable 2 is high (1). A deselected port writes nothing and its read data holds its previous value.
- R4: With output enable low, the port's read data is zero at once, without a clock edge. Raising it again shows the held register value.
- R5: A selected port with forwarding high (1) places its captured write data on the other port's read data one edge later. This overrides a read on that other port. The forwarding port writes nothing to the array. When both ports forward, the data crosses over.
- R6: When one port writes and the other reads the same address in the same cycle, the reader gets the contents from before the write, and the new data is stored.
- R7: When both ports write the same address in the same cycle, only port Y's data is stored.
- R8: The ready flag is low in reset and during the first edge after reset is released. Operations presented at that edge are ignored. Afterwards ready stays high.
- R9: When both ports read the same address in the same cycle, both receive the stored word.
- R10: Reset clears both read data registers to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ready | output | 1 | High once the start-up idle edge has passed |
| x_addr | input | ADDR_W | Port X word address |
| x_wdata | input | DATA_W | Port X write / forward data |
| x_ce1_n | input | 1 | Port X chip enable 1, active low |
| x_ce2 | input | 1 | Port X chip enable 2, active high |
| x_we_n | input | 1 | Port X write enable, active low |
| x_fwd | input | 1 | Port X forward to port Y |
| x_oe | input | 1 | Port X output enable, active high, asynchronous |
| x_rdata | output | DATA_W | Port X read data |
| y_addr | input | ADDR_W | Port Y word address |
| y_wdata | input | DATA_W | Port Y write / forward data |
| y_ce1_n | input | 1 | Port Y chip enable 1, active low |
| y_ce2 | input | 1 | Port Y chip enable 2, active high |
| y_we_n | input | 1 | Port Y write enable, active low |
| y_fwd | input | 1 | Port Y forward to port X |
| y_oe | input | 1 | Port Y output enable, active high, asynchronous |
| y_rdata | output | DATA_W | Port Y read data |

## Verification
The hardest case to reach is two ports acting on the same word in the same cycle. A read must land in the same edge as the write, so that the read-before-write and Y-wins rules are really exercised. The stimulus table drives both ports in one vector with equal addresses and different opcodes, then reads the word back in a later vector to show what was stored. Forwarding that overrides a read, and forwarding in both directions at once, are reached the same way. The forwarding port's own address is then read back to show that the array did not change.

// File: rtl/dpr_pkg.sv
// Package: shared operation encoding for the dual-port RAM.
// Assumes: one operation per port per cycle, decided at capture time.
package dpr_pkg;
    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2,
        OP_FWD   = 2'd3
    } port_op_t;
endpackage

// File: rtl/dpr_capture.sv
// Module: input capture stage of one port. Registers address and data and
// decodes the controls into a single operation.
// Assumes: ready_i is low for the start-up edge; reset is synchronous, active low.
module dpr_capture
    import dpr_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 36
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ready_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              ce1_n_i,
    input  logic              ce2_i,
    input  logic              we_n_i,
    input  logic              fwd_i,
    output port_op_t          op_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] data_o
);
    logic     selected;
    port_op_t op_next;

    // Decode the operation: forwarding beats writing, writing beats reading.
    always_comb begin
        selected = ready_i && !ce1_n_i && ce2_i;
        if (!selected)   op_next = OP_IDLE;
        else if (fwd_i)  op_next = OP_FWD;
        else if (!we_n_i) op_next = OP_WRITE;
        else             op_next = OP_READ;
    end

    // Register the operation, address and data on the rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_o   <= OP_IDLE;
            addr_o <= '0;
            data_o <= '0;
        end else begin
            op_o   <= op_next;
            addr_o <= addr_i;
            data_o <= wdata_i;
        end
    end
endmodule

// File: rtl/dpr_array.sv
// Module: shared storage array with two captured ports.
// Reads are combinational from the array, so a register loaded on the same
// edge as a write sees the old word. When both ports write one address, the
// Y assignment comes last and wins.
// Assumes: ops arrive already registered from dpr_capture.
module dpr_array
    import dpr_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 36
) (
    input  logic              clk,
    input  logic              rst_n,
    input  port_op_t          x_op,
    input  logic [ADDR_W-1:0] x_addr,
    input  logic [DATA_W-1:0] x_data,
    input  port_op_t          y_op,
    input  logic [ADDR_W-1:0] y_addr,
    input  logic [DATA_W-1:0] y_data,
    output logic [DATA_W-1:0] x_rd,
    output logic [DATA_W-1:0] y_rd
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Present the current array contents at each port's captured address.
    always_comb begin
        x_rd = mem[x_addr];
        y_rd = mem[y_addr];
    end

    // Commit writes; port Y is written second so it wins a collision.
    always_ff @(posedge clk) begin
        if (x_op == OP_WRITE) mem[x_addr] <= x_data;
        if (y_op == OP_WRITE) mem[y_addr] <= y_data;
    end

    assert_y_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (x_op == OP_WRITE && y_op == OP_WRITE && x_addr == y_addr)
        |=> mem[$past(y_addr)] == $past(y_data));
endmodule

// File: rtl/dpr_outreg.sv
// Module: read data register of one port with an asynchronous output gate.
// A forward from the peer takes priority over the port's own read; with
// neither, the register holds.
// Assumes: own_op and peer_op are the captured operations.
module dpr_outreg
    import dpr_pkg::*;
#(
    parameter int DATA_W = 36
) (
    input  logic              clk,
    input  logic              rst_n,
    input  port_op_t          own_op,
    input  logic [DATA_W-1:0] own_rd,
    input  port_op_t          peer_op,
    input  logic [DATA_W-1:0] peer_data,
    input  logic              oe,
    output logic [DATA_W-1:0] q_o,
    output logic [DATA_W-1:0] rdata
);
    // Load forwarded data, else read data, else keep the old value.
    always_ff @(posedge clk) begin
        if (!rst_n)                q_o <= '0;
        else if (peer_op == OP_FWD) q_o <= peer_data;
        else if (own_op == OP_READ) q_o <= own_rd;
    end

    // Gate the register onto the port without any clock involvement.
    always_comb begin
        rdata = oe ? q_o : '0;
    end

    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (own_op != OP_READ && peer_op != OP_FWD) |=> $stable(q_o));
endmodule

// File: rtl/dpr_top.sv
// Module: dual-port synchronous RAM with port-to-port forwarding.
// Two capture stages feed one shared array and two output registers.
// Assumes: synchronous active-low reset; the first edge after reset is idle.
module dpr_top
    import dpr_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 36
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              ready,
    input  logic [ADDR_W-1:0] x_addr,
    input  logic [DATA_W-1:0] x_wdata,
    input  logic              x_ce1_n,
    input  logic              x_ce2,
    input  logic              x_we_n,
    input  logic              x_fwd,
    input  logic              x_oe,
    output logic [DATA_W-1:0] x_rdata,
    input  logic [ADDR_W-1:0] y_addr,
    input  logic [DATA_W-1:0] y_wdata,
    input  logic              y_ce1_n,
    input  logic              y_ce2,
    input  logic              y_we_n,
    input  logic              y_fwd,
    input  logic              y_oe,
    output logic [DATA_W-1:0] y_rdata
);
    port_op_t          x_op, y_op;
    logic [ADDR_W-1:0] x_a, y_a;
    logic [DATA_W-1:0] x_d, y_d;
    logic [DATA_W-1:0] x_rd, y_rd;
    logic [DATA_W-1:0] x_q, y_q;

    // Raise ready one edge after reset release and keep it high.
    always_ff @(posedge clk) begin
        if (!rst_n) ready <= 1'b0;
        else        ready <= 1'b1;
    end

    dpr_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cap_x (
        .clk(clk), .rst_n(rst_n), .ready_i(ready),
        .addr_i(x_addr), .wdata_i(x_wdata), .ce1_n_i(x_ce1_n), .ce2_i(x_ce2),
        .we_n_i(x_we_n), .fwd_i(x_fwd),
        .op_o(x_op), .addr_o(x_a), .data_o(x_d));

    dpr_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cap_y (
        .clk(clk), .rst_n(rst_n), .ready_i(ready),
        .addr_i(y_addr), .wdata_i(y_wdata), .ce1_n_i(y_ce1_n), .ce2_i(y_ce2),
        .we_n_i(y_we_n), .fwd_i(y_fwd),
        .op_o(y_op), .addr_o(y_a), .data_o(y_d));

    dpr_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk(clk), .rst_n(rst_n),
        .x_op(x_op), .x_addr(x_a), .x_data(x_d),
        .y_op(y_op), .y_addr(y_a), .y_data(y_d),
        .x_rd(x_rd), .y_rd(y_rd));

    dpr_outreg #(.DATA_W(DATA_W)) u_out_x (
        .clk(clk), .rst_n(rst_n),
        .own_op(x_op), .own_rd(x_rd), .peer_op(y_op), .peer_data(y_d),
        .oe(x_oe), .q_o(x_q), .rdata(x_rdata));

    dpr_outreg #(.DATA_W(DATA_W)) u_out_y (
        .clk(clk), .rst_n(rst_n),
        .own_op(y_op), .own_rd(y_rd), .peer_op(x_op), .peer_data(x_d),
        .oe(y_oe), .q_o(y_q), .rdata(y_rdata));

    assert_ready_stays_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready);

    assert_idle_before_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |=> (x_op == OP_IDLE && y_op == OP_IDLE));

    assert_fwd_x_to_y_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (x_op == OP_FWD) |=> y_q == $past(x_d));

    assert_fwd_y_to_x_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (y_op == OP_FWD) |=> x_q == $past(y_d));
endmodule

// File: tb/tb_dpr_top.sv
module tb_dpr_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 8;
    localparam int DW = 36;

    typedef struct packed {
        logic [AW-1:0] xa;
        logic [DW-1:0] xd;
        logic          xce1n, xce2, xwen, xfwd;
        logic [AW-1:0] ya;
        logic [DW-1:0] yd;
        logic          yce1n, yce2, ywen, yfwd;
        logic [DW-1:0] ex, ey;
    } vec_t;

    localparam int NV = 14;
    // Fields: xa xd ce1n ce2 wen fwd | ya yd ce1n ce2 wen fwd | exp_x exp_y
    localparam vec_t VEC [NV] = '{
        '{8'd5, 36'hA1, 1'b0,1'b1,1'b0,1'b0, 8'd9, 36'hB2, 1'b0,1'b1,1'b0,1'b0, 36'h0,  36'h0 },  // R2 writes, outputs hold
        '{8'd9, 36'h0,  1'b0,1'b1,1'b1,1'b0, 8'd5, 36'h0,  1'b0,1'b1,1'b1,1'b0, 36'hB2, 36'hA1},  // R2 read back
        '{8'd5, 36'h0,  1'b0,1'b1,1'b1,1'b0, 8'd5, 36'h0,  1'b0,1'b1,1'b1,1'b0, 36'hA1, 36'hA1},  // R9 same-address reads
        '{8'd5, 36'hC3, 1'b0,1'b1,1'b0,1'b0, 8'd5, 36'h0,  1'b0,1'b1,1'b1,1'b0, 36'hA1, 36'hA1},  // R6 Y reads old
        '{8'd5, 36'h0,  1'b0,1'b1,1'b1,1'b0, 8'd0, 36'h0,  1'b1,1'b0,1'b1,1'b0, 36'hC3, 36'hA1},  // R6 new stored, R3 hold
        '{8'd7, 36'hD4, 1'b0,1'b1,1'b0,1'b0, 8'd7, 36'hE5, 1'b0,1'b1,1'b0,1'b0, 36'hC3, 36'hA1},  // R7 double write
        '{8'd7, 36'h0,  1'b0,1'b1,1'b1,1'b0, 8'd7, 36'h0,  1'b0,1'b1,1'b1,1'b0, 36'hE5, 36'hE5},  // R7 Y won
        '{8'd5, 36'hF6, 1'b0,1'b1,1'b0,1'b1, 8'd5, 36'h0,  1'b0,1'b1,1'b1,1'b0, 36'hE5, 36'hF6},  // R5 forward beats read
        '{8'd5, 36'h88, 1'b0,1'b1,1'b1,1'b1, 8'd5, 36'h77, 1'b0,1'b1,1'b1,1'b1, 36'h77, 36'h88},  // R5 crossover
        '{8'd5, 36'h0,  1'b0,1'b1,1'b1,1'b0, 8'd0, 36'h0,  1'b1,1'b0,1'b1,1'b0, 36'hC3, 36'h88},  // R5 forward wrote nothing
        '{8'd9, 36'h99, 1'b0,1'b0,1'b0,1'b0, 8'd5, 36'h11, 1'b1,1'b1,1'b0,1'b0, 36'hC3, 36'h88},  // R3 half-selected writes
        '{8'd9, 36'h0,  1'b0,1'b1,1'b1,1'b0, 8'd5, 36'h0,  1'b0,1'b1,1'b1,1'b0, 36'hB2, 36'hC3},  // R3 nothing stored
        '{8'd9, 36'h0,  1'b0,1'b1,1'b1,1'b0, 8'd9, 36'hAB, 1'b0,1'b1,1'b0,1'b0, 36'hB2, 36'hC3},  // R6 X reads old
        '{8'd9, 36'h0,  1'b0,1'b1,1'b1,1'b0, 8'd0, 36'h0,  1'b1,1'b0,1'b1,1'b0, 36'hAB, 36'hC3}   // R6 new stored
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ready;
    logic [AW-1:0] x_addr = '0, y_addr = '0;
    logic [DW-1:0] x_wdata = '0, y_wdata = '0;
    logic          x_ce1_n = 1'b1, x_ce2 = 1'b0, x_we_n = 1'b1, x_fwd = 1'b0, x_oe = 1'b1;
    logic          y_ce1_n = 1'b1, y_ce2 = 1'b0, y_we_n = 1'b1, y_fwd = 1'b0, y_oe = 1'b1;
    logic [DW-1:0] x_rdata, y_rdata;
    int            n_checks = 0;
    int            n_fail = 0;
    bit            done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dpr_top #(.ADDR_W(AW), .DATA_W(DW)) dut (
        .clk(clk), .rst_n(rst_n), .ready(ready),
        .x_addr(x_addr), .x_wdata(x_wdata), .x_ce1_n(x_ce1_n), .x_ce2(x_ce2),
        .x_we_n(x_we_n), .x_fwd(x_fwd), .x_oe(x_oe), .x_rdata(x_rdata),
        .y_addr(y_addr), .y_wdata(y_wdata), .y_ce1_n(y_ce1_n), .y_ce2(y_ce2),
        .y_we_n(y_we_n), .y_fwd(y_fwd), .y_oe(y_oe), .y_rdata(y_rdata));

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic deselect();
        x_ce1_n = 1'b1; x_ce2 = 1'b0; x_we_n = 1'b1; x_fwd = 1'b0;
        y_ce1_n = 1'b1; y_ce2 = 1'b0; y_we_n = 1'b1; y_fwd = 1'b0;
    endtask

    task automatic drive(input vec_t v);
        x_addr = v.xa; x_wdata = v.xd; x_ce1_n = v.xce1n; x_ce2 = v.xce2;
        x_we_n = v.xwen; x_fwd = v.xfwd;
        y_addr = v.ya; y_wdata = v.yd; y_ce1_n = v.yce1n; y_ce2 = v.yce2;
        y_we_n = v.ywen; y_fwd = v.yfwd;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        // R10: reset clears read data; R8 ready low in reset
        repeat (3) @(negedge clk);
        check("R10 x_rdata in reset", x_rdata, '0);
        check("R10 y_rdata in reset", y_rdata, '0);
        check("R8 ready in reset", {{(DW-1){1'b0}}, ready}, '0);

        // R8: forward presented at the first edge after release is ignored
        rst_n = 1'b1;
        x_ce1_n = 1'b0; x_ce2 = 1'b1; x_fwd = 1'b1; x_wdata = 36'h123;
        @(negedge clk);
        check("R8 ready after first edge", {{(DW-1){1'b0}}, ready}, 36'h1);
        deselect();
        @(negedge clk);
        check("R8 start-up forward ignored", y_rdata, '0);

        // Table walk: capture edge, result edge, sample
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i]);
            @(negedge clk);
            deselect();
            @(negedge clk);
            check($sformatf("vector %0d x", i), x_rdata, VEC[i].ex);
            check($sformatf("vector %0d y", i), y_rdata, VEC[i].ey);
        end

        // R1: latency of two edges
        x_addr = 8'd5; x_ce1_n = 1'b0; x_ce2 = 1'b1; x_we_n = 1'b1;
        @(negedge clk);
        deselect();
        check("R1 not after one edge", x_rdata, 36'hAB);
        @(negedge clk);
        check("R1 after second edge", x_rdata, 36'hC3);

        // R4: asynchronous output gate
        x_oe = 1'b0;
        #1;
        check("R4 gate low", x_rdata, '0);
        x_oe = 1'b1;
        #1;
        check("R4 gate high restores", x_rdata, 36'hC3);

        // R10: reset mid-run clears registers, R8 ready drops
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R10 x cleared", x_rdata, '0);
        check("R10 y cleared", y_rdata, '0);
        check("R8 ready cleared", {{(DW-1){1'b0}}, ready}, '0);

        $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        done = 1'b1;
        $finish;
    end
endmodule